// File: doc/BRIEF.md
# Serial Configuration Port for a Camera Front End

This block is the control-side entry point of a camera analog front end. A host drives three wires (a serial clock, a serial data line and an active-low frame enable), and the block shifts in 13-bit frames. Each frame carries a 3-bit register selector followed by a 10-bit payload. When the enable returns high after exactly 13 accepted bits, the payload is written into one of five configuration registers. The decoded fields drive the converters and amplifiers downstream: an auxiliary 8-bit DAC code, two 4-bit bandwidth codes, a saturated 9-bit gain code, three partial power-down enables, three edge or level polarity selects and a 10-bit clamp-level code.

The three serial inputs are asynchronous to the system clock. They are brought into the system clock domain through a synchronizer, and all edges are detected on the synchronized copies. The serial clock must therefore run several times slower than the system clock. Bits are sampled on rising serial clock edges. A frame with too few bits, too many bits or an unused selector leaves every register unchanged.

Top module: `ctl_serial_port`

## Requirements
- R1: After reset every code output is 0, all three power-down enables are 0, `pulse_fall` and `clamp_act_high` are 0, and `conv_clk_fall` is 1.
- R2: Frame bits are taken MSB first on rising `ser_clk` edges while `ser_en_n` is low: selector bits 2..0, then payload bits 9..0. Selector 000 loads payload bits 7..0 into `aux_code`.
- R3: Selector 001 loads payload bits 3..0 into `bw_cds` and payload bits 7..4 into `bw_agc`. Bits 9..8 are ignored.
- R4: Selector 010 stores payload bits 8..0 as the gain. `gain_code` equals the stored value when it is below 319 and equals 319 otherwise.
- R5: Selector 011 decodes the payload bits as follows: bit0 drives `sby_cds_agc`, bit1 drives `sby_aux`, bit2 drives `sby_amp`, bit3 drives `pulse_fall`, bit4 drives `clamp_act_high`, and `conv_clk_fall` is the inverse of bit5.
- R6: Selector 100 loads all ten payload bits into `clamp_code`.
- R7: A register is written only when exactly 13 bits were accepted between the fall and the rise of `ser_en_n`. A frame of 12 or 14 bits changes no output.
- R8: Selectors 101, 110 and 111 change no output.
- R9: Rising `ser_clk` edges while `ser_en_n` is high shift nothing. A complete frame sent afterwards is decoded normally.
- R10: When the 13th rising `ser_clk` edge and the rise of `ser_en_n` reach the block in the same system clock cycle, that bit counts and the frame is committed.
- R11: A committed frame changes only the fields of the register it selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_en_n | input | 1 | Frame enable, active low, asynchronous |
| aux_code | output | 8 | Auxiliary DAC code |
| bw_cds | output | 4 | Sampler bandwidth code |
| bw_agc | output | 4 | Gain stage bandwidth code |
| gain_code | output | 9 | Gain code, saturated at 319 |
| sby_cds_agc | output | 1 | Sampler and gain stage power-down |
| sby_aux | output | 1 | Auxiliary DAC power-down |
| sby_amp | output | 1 | Fixed-gain output amplifier power-down |
| pulse_fall | output | 1 | Sampling pulses act on their falling edge |
| clamp_act_high | output | 1 | Clamp pulses are active high |
| conv_clk_fall | output | 1 | Converter clock acts on its falling edge |
| clamp_code | output | 10 | Clamp reference code |

## Verification
Two actions can fall in the same synchronized cycle: shifting in the final bit and committing the frame on the release of the enable. The bench provokes this by raising `ser_clk` and `ser_en_n` in the same system clock cycle on the last bit. It then expects the clamp register to hold the full payload, which shows that the bit was both counted and shifted before the commit. The near-miss cases of 12 and 14 bits show that the bit count is judged exactly at that commit.

// File: rtl/ctl_port_pkg.sv
package ctl_port_pkg;

    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 10;
    localparam int FRAME_W  = ADDR_W + DATA_W;
    localparam int GAIN_W   = 9;
    localparam int GAIN_MAX = 319;
    localparam int CTL_W    = 6;

    localparam logic [ADDR_W-1:0] SEL_AUX   = 3'd0;
    localparam logic [ADDR_W-1:0] SEL_BW    = 3'd1;
    localparam logic [ADDR_W-1:0] SEL_GAIN  = 3'd2;
    localparam logic [ADDR_W-1:0] SEL_CTL   = 3'd3;
    localparam logic [ADDR_W-1:0] SEL_CLAMP = 3'd4;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef struct packed {
        logic [7:0]        aux;
        logic [3:0]        bw_agc;
        logic [3:0]        bw_cds;
        logic [GAIN_W-1:0] gain;
        logic [CTL_W-1:0]  ctl;
        logic [DATA_W-1:0] clamp;
    } cfg_t;

    function automatic logic [GAIN_W-1:0] sat_gain(input logic [GAIN_W-1:0] g);
        return (g > GAIN_W'(GAIN_MAX)) ? GAIN_W'(GAIN_MAX) : g;
    endfunction

endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
    parameter int              STAGES  = 2,
    parameter int              WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) st[0] <= RST_VAL;
        else     st[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) st[i] <= RST_VAL;
            else     st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/sp_shifter.sv
module sp_shifter
    import ctl_port_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sclk_s,
    input  logic   sdat_s,
    input  logic   sen_n_s,
    output logic   frm_valid,
    output frame_t frm
);
    localparam int CNT_MAX = FRAME_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic               clk_d, en_d;
    logic [FRAME_W-1:0] sreg, sreg_nxt;
    logic [CNT_W-1:0]   cnt, cnt_nxt;
    logic               take, en_rise;

    // A bit counts if the enable was low at the previous sample, so a
    // final clock edge that coincides with the enable release is kept.
    assign take    = sclk_s & ~clk_d & ~en_d;
    assign en_rise = sen_n_s & ~en_d;

    always_comb begin
        sreg_nxt = sreg;
        cnt_nxt  = cnt;
        if (take) begin
            sreg_nxt = {sreg[FRAME_W-2:0], sdat_s};
            if (cnt != CNT_W'(CNT_MAX)) cnt_nxt = cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_d     <= 1'b0;
            en_d      <= 1'b1;
            sreg      <= '0;
            cnt       <= '0;
            frm_valid <= 1'b0;
            frm       <= '0;
        end else begin
            clk_d     <= sclk_s;
            en_d      <= sen_n_s;
            sreg      <= sreg_nxt;
            cnt       <= sen_n_s ? '0 : cnt_nxt;
            frm_valid <= en_rise && (cnt_nxt == CNT_W'(FRAME_W));
            frm       <= frame_t'(sreg_nxt);
        end
    end
endmodule

// File: rtl/sp_regfile.sv
module sp_regfile
    import ctl_port_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   frm_valid,
    input  frame_t frm,
    output cfg_t   cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (frm_valid) begin
            case (frm.addr)
                SEL_AUX:   cfg.aux <= frm.data[7:0];
                SEL_BW: begin
                    cfg.bw_cds <= frm.data[3:0];
                    cfg.bw_agc <= frm.data[7:4];
                end
                SEL_GAIN:  cfg.gain  <= frm.data[GAIN_W-1:0];
                SEL_CTL:   cfg.ctl   <= frm.data[CTL_W-1:0];
                SEL_CLAMP: cfg.clamp <= frm.data;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/ctl_serial_port.sv
module ctl_serial_port
    import ctl_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_en_n,
    output logic [7:0]        aux_code,
    output logic [3:0]        bw_cds,
    output logic [3:0]        bw_agc,
    output logic [GAIN_W-1:0] gain_code,
    output logic              sby_cds_agc,
    output logic              sby_aux,
    output logic              sby_amp,
    output logic              pulse_fall,
    output logic              clamp_act_high,
    output logic              conv_clk_fall,
    output logic [DATA_W-1:0] clamp_code
);
    logic [2:0] raw_in, sync_out;
    logic       frm_valid;
    frame_t     frm;
    cfg_t       cfg;

    assign raw_in = {ser_clk, ser_dat, ser_en_n};

    sp_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b001)) u_sync (
        .clk(clk), .rst(rst), .d(raw_in), .q(sync_out)
    );

    sp_shifter u_shift (
        .clk(clk), .rst(rst),
        .sclk_s(sync_out[2]), .sdat_s(sync_out[1]), .sen_n_s(sync_out[0]),
        .frm_valid(frm_valid), .frm(frm)
    );

    sp_regfile u_regs (
        .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm(frm), .cfg(cfg)
    );

    assign aux_code       = cfg.aux;
    assign bw_cds         = cfg.bw_cds;
    assign bw_agc         = cfg.bw_agc;
    assign gain_code      = sat_gain(cfg.gain);
    assign sby_cds_agc    = cfg.ctl[0];
    assign sby_aux        = cfg.ctl[1];
    assign sby_amp        = cfg.ctl[2];
    assign pulse_fall     = cfg.ctl[3];
    assign clamp_act_high = cfg.ctl[4];
    assign conv_clk_fall  = ~cfg.ctl[5];
    assign clamp_code     = cfg.clamp;
endmodule

// File: rtl/ctl_serial_port_chk.sv
module ctl_serial_port_chk
    import ctl_port_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              frm_valid,
    input frame_t            frm,
    input logic [7:0]        aux_code,
    input logic [3:0]        bw_cds,
    input logic [3:0]        bw_agc,
    input logic [GAIN_W-1:0] gain_code,
    input logic              sby_cds_agc,
    input logic              sby_aux,
    input logic              sby_amp,
    input logic              pulse_fall,
    input logic              clamp_act_high,
    input logic              conv_clk_fall,
    input logic [DATA_W-1:0] clamp_code
);
    logic [40:0] outs;
    assign outs = {aux_code, bw_cds, bw_agc, gain_code, sby_cds_agc, sby_aux,
                   sby_amp, pulse_fall, clamp_act_high, conv_clk_fall, clamp_code};

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> outs == {8'd0, 4'd0, 4'd0, 9'd0, 5'b00000, 1'b1, 10'd0});

    a_r4_gain_capped: assert property (@(posedge clk) disable iff (rst)
        gain_code <= GAIN_W'(GAIN_MAX));

    a_r7_quiet_without_commit: assert property (@(posedge clk) disable iff (rst)
        !$past(frm_valid) |-> $stable(outs));

    a_r8_unused_select: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm.addr > SEL_CLAMP) |=> $stable(outs));

    a_r6_clamp_load: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm.addr == SEL_CLAMP) |=> clamp_code == $past(frm.data));

    a_r3_bw_load: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm.addr == SEL_BW) |=>
            (bw_cds == $past(frm.data[3:0]) && bw_agc == $past(frm.data[7:4])));
endmodule

bind ctl_serial_port ctl_serial_port_chk u_chk (.*);

// File: tb/ctl_serial_port_bench.sv
module ctl_serial_port_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en_n = 1'b1;
    logic [7:0] aux_code;
    logic [3:0] bw_cds, bw_agc;
    logic [8:0] gain_code;
    logic sby_cds_agc, sby_aux, sby_amp, pulse_fall, clamp_act_high, conv_clk_fall;
    logic [9:0] clamp_code;

    ctl_serial_port u_ctl_serial_port (.*);

    always #5 clk = ~clk;

    typedef struct { logic [40:0] v; string tag; } exp_t;
    exp_t q[$];
    int errors = 0, checks = 0;
    bit done = 1'b0;

    // independent expectation model
    logic [7:0] m_aux = 0;
    logic [3:0] m_cds = 0, m_agc = 0;
    logic [8:0] m_gain = 0;
    logic m_s0 = 0, m_s1 = 0, m_s2 = 0, m_pf = 0, m_ch = 0, m_cf = 1;
    logic [9:0] m_clamp = 0;

    function automatic logic [40:0] model_vec();
        return {m_aux, m_cds, m_agc, m_gain, m_s0, m_s1, m_s2, m_pf, m_ch, m_cf, m_clamp};
    endfunction

    task automatic apply(input logic [2:0] a, input logic [9:0] d);
        case (a)
            3'd0: m_aux = d[7:0];
            3'd1: begin m_cds = d[3:0]; m_agc = d[7:4]; end
            3'd2: m_gain = (d[8:0] >= 9'd319) ? 9'd319 : d[8:0];
            3'd3: begin m_s0 = d[0]; m_s1 = d[1]; m_s2 = d[2];
                        m_pf = d[3]; m_ch = d[4]; m_cf = ~d[5]; end
            3'd4: m_clamp = d;
            default: ;
        endcase
    endtask

    task automatic push(input string tag);
        exp_t e;
        e.v = model_vec();
        e.tag = tag;
        q.push_back(e);
        repeat (24) @(negedge clk);
    endtask

    // n bits MSB first; merge raises the enable together with the last clock edge
    task automatic send_bits(input logic [15:0] bits, input int n, input bit merge);
        ser_en_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = bits[i];
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
            if (merge && i == 0) ser_en_n = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (4) @(negedge clk);
        ser_en_n = 1'b1;
    endtask

    task automatic frame(input logic [2:0] a, input logic [9:0] d, input string tag);
        send_bits({3'b000, a, d}, 13, 1'b0);
        apply(a, d);
        push(tag);
    endtask

    // monitor: compare every expectation after the sync and register latency
    initial begin
        forever begin
            wait (q.size() != 0);
            repeat (12) @(negedge clk);
            begin
                exp_t e;
                logic [40:0] act;
                e = q.pop_front();
                act = {aux_code, bw_cds, bw_agc, gain_code, sby_cds_agc, sby_aux, sby_amp,
                       pulse_fall, clamp_act_high, conv_clk_fall, clamp_code};
                checks++;
                if (act !== e.v) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h", e.tag, act, e.v);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        push("R1 reset state");
        frame(3'd0, 10'h3A5, "R2 aux load");
        frame(3'd1, 10'h3B7, "R3 bandwidth split");
        frame(3'd2, 10'd400, "R4 gain above cap");
        frame(3'd2, 10'd318, "R4 gain below cap");
        frame(3'd2, 10'd319, "R4 gain at cap");
        frame(3'd2, 10'h1FF, "R4 gain max code");
        frame(3'd3, 10'h03F, "R5 all control bits set");
        frame(3'd3, 10'h015, "R5 mixed control bits");
        frame(3'd4, 10'h2C3, "R6 clamp load");
        send_bits({4'b0000, 3'd4, 9'h0F0}, 12, 1'b0);
        push("R7 short frame discarded");
        send_bits({2'b00, 1'b0, 3'd4, 10'h111}, 14, 1'b0);
        push("R7 long frame discarded");
        frame(3'd5, 10'h3FF, "R8 select 5 discarded");
        frame(3'd7, 10'h155, "R8 select 7 discarded");
        // clocks with enable high
        for (int i = 0; i < 13; i++) begin
            ser_dat = i[0];
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
        end
        push("R9 clocks ignored with enable high");
        frame(3'd0, 10'h05A, "R9 frame after idle clocks");
        send_bits({3'b000, 3'd4, 10'h155}, 13, 1'b1);
        apply(3'd4, 10'h155);
        push("R10 last edge with enable release");
        frame(3'd1, 10'h0C4, "R11 only bandwidth changes");
        wait (q.size() == 0);
        repeat (20) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule